// File: doc/BRIEF.md
# Fixed Off-Time Winding Current Chopper

This block regulates the current in one motor winding by chopping the four switches of one H-bridge. While the winding is driven, one diagonal pair of switches is on: the high side of one leg and the low side of the other. The direction input picks which diagonal is used. When the external current-sense comparator reports that the trip level has been reached, the drive stops and a fixed off-time begins. During the off-time the current decays, either entirely through both low-side switches (slow decay) or first through the reversed diagonal (fast decay) and then through the low sides. When the off-time expires, the block drives the winding again.

After every phase change the block holds all four gates low for a short dead interval. After entering drive it also ignores the comparator for a blanking window of about 1 µs, so switching transients cannot cause a false trip. The recirculating switches are released as soon as a zero-current indication arrives, so the load current never reverses. All times are counted in clock cycles. The off-time comes from an input, or from a built-in default when that input is zero. Sense conditioning, reference generation, gate-driver dead time and fault latching belong to the surrounding logic.

Top module: `pwm_chopper`

## Requirements
- R1: While `enable` is low, all four gate outputs are low in that same cycle, and the sequencer is idle from the next cycle on. Reset leaves it idle. The cycle after `enable` rises, a fresh drive phase starts.
- R2: Gates are written {A-high, A-low, B-high, B-low}. In drive, `dir`=1 gives 1001 and `dir`=0 gives 0110. The polarity is sampled when a drive phase is entered and is held until that drive phase ends.
- R3: For the first DEAD_CYC cycles after any change of phase, all four gates are low.
- R4: In drive, `sense_trip` is ignored during the first DEAD_CYC+CLK_MHZ cycles of the phase. It is accepted on any later drive cycle.
- R5: An accepted trip starts the off phase in the next cycle. The off phase lasts exactly the off-time in cycles, and drive follows directly after it.
- R6: With `mixed_req`=1, the first floor(5*off/16) off cycles are fast decay, with the reversed diagonal (dir=1: 0110; dir=0: 1001). The remaining off cycles are slow decay (0101).
- R7: With `mixed_req`=0, or when floor(5*off/16) is 0, the whole off phase is slow decay (0101).
- R8: A `zero_cross` pulse during the off phase forces all gates low from that cycle until the off phase ends. The following drive phase is unaffected.
- R9: `off_cycles`=0 selects the default off-time. This is 30*CLK_MHZ cycles, or ROSC_OHM*CLK_MHZ/825 cycles when ROSC_OHM is nonzero.
- R10: With the trip held high (shorted load), the chopper repeats drive and off with a period of DEAD_CYC+CLK_MHZ+1+off cycles.
- R11: The high side and low side of one leg are never on together.
- R12: `mixed_req` and `off_cycles` are sampled only when a trip is accepted. Changes during an off phase do not alter that off phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Output enable; low forces all gates off and idles the sequencer |
| dir | input | 1 | Bridge polarity for the drive diagonal |
| mixed_req | input | 1 | Decay mode request: 1 mixed, 0 slow |
| sense_trip | input | 1 | Current-sense comparator output |
| zero_cross | input | 1 | Winding current has reached zero |
| off_cycles | input | OFF_W | Off-time in clock cycles, 0 selects the default |
| gate_ah | output | 1 | Leg A high-side gate enable |
| gate_al | output | 1 | Leg A low-side gate enable |
| gate_bh | output | 1 | Leg B high-side gate enable |
| gate_bl | output | 1 | Leg B low-side gate enable |

## Verification
A wrong phase or cycle count is visible at the gates within one chopping period. A shortened or lengthened off-time moves the cycle where the drive diagonal reappears. A wrong fast-decay count moves the edge from the reversed diagonal to the low-side pair. A broken blanking window shifts the trip by at least one cycle. A missing dead interval or a wrong latched polarity shows in the first cycle of a phase. Because every cycle of two full periods is compared against an arithmetic model, across all modes, both polarities and a sweep of off-times, each of these faults appears as a mismatch within a few cycles.

// File: rtl/pwm_chopper_pkg.sv
package pwm_chopper_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRIVE = 2'd1,
    PH_FAST  = 2'd2,
    PH_SLOW  = 2'd3
  } phase_t;

  // fast-decay share of the off-time: FAST_NUM / 2**FAST_SHIFT
  localparam int unsigned FAST_NUM   = 5;
  localparam int unsigned FAST_SHIFT = 4;

  // gate vectors, ordered {A-high, A-low, B-high, B-low}
  localparam logic [3:0] GV_DIAG_AB = 4'b1001;
  localparam logic [3:0] GV_DIAG_BA = 4'b0110;
  localparam logic [3:0] GV_LOWS    = 4'b0101;

endpackage

// File: rtl/pwm_chopper_window.sv
module pwm_chopper_window #(
  parameter int unsigned DEAD_CYC = 1,
  parameter int unsigned WIN      = 5,
  parameter int unsigned PC_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  output logic            dead_o,
  output logic            armed_o,
  output logic [PC_W-1:0] pc_o
);

  localparam logic [PC_W-1:0] WIN_V  = PC_W'(WIN);
  localparam logic [PC_W-1:0] DEAD_V = PC_W'(DEAD_CYC);

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    if (restart)            pc_d = '0;
    else if (pc_q == WIN_V) pc_d = pc_q;
    else                    pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign dead_o  = (pc_q < DEAD_V);
  assign armed_o = (pc_q == WIN_V);
  assign pc_o    = pc_q;

endmodule

// File: rtl/pwm_chopper_offtime.sv
module pwm_chopper_offtime
  import pwm_chopper_pkg::*;
#(
  parameter int unsigned OFF_W    = 8,
  parameter int unsigned CLK_MHZ  = 4,
  parameter int unsigned ROSC_OHM = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic             mixed_req,
  input  logic [OFF_W-1:0] off_cycles,
  output logic             fast_pick_o,
  output logic             fast_last_o,
  output logic             off_last_o
);

  localparam int unsigned DEF_INT = (ROSC_OHM == 0) ? (30 * CLK_MHZ)
                                                    : (ROSC_OHM * CLK_MHZ / 825);
  localparam logic [OFF_W-1:0] DEF_OFF = OFF_W'(DEF_INT);
  localparam int unsigned PW = OFF_W + 3;

  logic [OFF_W-1:0] eff, fast_now;
  logic [PW-1:0]    prod;
  logic [OFF_W-1:0] len_q, len_d, fast_q, fast_d, oc_q, oc_d;

  always_comb begin
    eff = (off_cycles == '0) ? DEF_OFF : off_cycles;
    if (eff == '0) eff = OFF_W'(1);
    prod     = PW'(eff) * PW'(FAST_NUM);
    fast_now = OFF_W'(prod >> FAST_SHIFT);
  end

  assign fast_pick_o = mixed_req && (fast_now != '0);

  always_comb begin
    len_d  = len_q;
    fast_d = fast_q;
    oc_d   = oc_q;
    if (load) begin
      len_d  = eff;
      fast_d = fast_now;
      oc_d   = '0;
    end else if (adv) begin
      oc_d   = oc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      fast_q <= '0;
      oc_q   <= '0;
    end else begin
      len_q  <= len_d;
      fast_q <= fast_d;
      oc_q   <= oc_d;
    end
  end

  assign fast_last_o = (({1'b0, oc_q} + 1'b1) == {1'b0, fast_q});
  assign off_last_o  = (({1'b0, oc_q} + 1'b1) == {1'b0, len_q});

endmodule

// File: rtl/pwm_chopper_fsm.sv
module pwm_chopper_fsm
  import pwm_chopper_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   dir,
  input  logic   sense_trip,
  input  logic   zero_cross,
  input  logic   armed,
  input  logic   fast_pick,
  input  logic   fast_last,
  input  logic   off_last,
  output phase_t ph_o,
  output logic   restart_o,
  output logic   load_o,
  output logic   adv_o,
  output logic   pol_o,
  output logic   zflag_o
);

  phase_t ph_q, ph_d;
  logic   pol_q, pol_d, zf_q, zf_d;
  logic   in_off;

  assign in_off = (ph_q == PH_FAST) || (ph_q == PH_SLOW);

  always_comb begin
    ph_d = ph_q;
    if (!enable) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE:  ph_d = PH_DRIVE;
        PH_DRIVE: if (armed && sense_trip) ph_d = fast_pick ? PH_FAST : PH_SLOW;
        PH_FAST:  if (fast_last) ph_d = PH_SLOW;
        PH_SLOW:  if (off_last)  ph_d = PH_DRIVE;
        default:  ph_d = PH_IDLE;
      endcase
    end
  end

  assign restart_o = (ph_d != ph_q);
  assign load_o    = (ph_q == PH_DRIVE) && ((ph_d == PH_FAST) || (ph_d == PH_SLOW));
  assign adv_o     = in_off;

  always_comb begin
    pol_d = pol_q;
    if ((ph_d == PH_DRIVE) && (ph_q != PH_DRIVE)) pol_d = dir;
  end

  always_comb begin
    zf_d = zf_q;
    if ((ph_d == PH_DRIVE) || (ph_d == PH_IDLE)) zf_d = 1'b0;
    else if (in_off && zero_cross)               zf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      pol_q <= 1'b0;
      zf_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      pol_q <= pol_d;
      zf_q  <= zf_d;
    end
  end

  assign ph_o    = ph_q;
  assign pol_o   = pol_q;
  assign zflag_o = zf_q;

endmodule

// File: rtl/pwm_chopper_gates.sv
module pwm_chopper_gates
  import pwm_chopper_pkg::*;
(
  input  logic       enable,
  input  phase_t     ph,
  input  logic       pol,
  input  logic       dead,
  input  logic       zero_cross,
  input  logic       zflag,
  output logic [3:0] gv_o
);

  logic released;

  always_comb begin
    released = ((ph == PH_FAST) || (ph == PH_SLOW)) && (zero_cross || zflag);
    unique case (ph)
      PH_DRIVE: gv_o = pol ? GV_DIAG_AB : GV_DIAG_BA;
      PH_FAST:  gv_o = pol ? GV_DIAG_BA : GV_DIAG_AB;
      PH_SLOW:  gv_o = GV_LOWS;
      default:  gv_o = 4'b0000;
    endcase
    if (!enable || dead || released) gv_o = 4'b0000;
  end

endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import pwm_chopper_pkg::*;
#(
  parameter int unsigned OFF_W    = 8,
  parameter int unsigned DEAD_CYC = 1,
  parameter int unsigned CLK_MHZ  = 4,
  parameter int unsigned ROSC_OHM = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dir,
  input  logic             mixed_req,
  input  logic             sense_trip,
  input  logic             zero_cross,
  input  logic [OFF_W-1:0] off_cycles,
  output logic             gate_ah,
  output logic             gate_al,
  output logic             gate_bh,
  output logic             gate_bl
);

  localparam int unsigned BLANK_CYC = (CLK_MHZ == 0) ? 1 : CLK_MHZ;
  localparam int unsigned WIN       = DEAD_CYC + BLANK_CYC;
  localparam int unsigned PC_W      = $clog2(WIN + 1);

  phase_t          ph;
  logic            restart, load, adv, pol, zflag;
  logic            dead, armed, fast_pick, fast_last, off_last;
  logic [PC_W-1:0] pc;
  logic [3:0]      gv;

  pwm_chopper_window #(.DEAD_CYC(DEAD_CYC), .WIN(WIN), .PC_W(PC_W)) u_window (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .dead_o(dead), .armed_o(armed), .pc_o(pc)
  );

  pwm_chopper_offtime #(.OFF_W(OFF_W), .CLK_MHZ(CLK_MHZ), .ROSC_OHM(ROSC_OHM)) u_offtime (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .mixed_req(mixed_req), .off_cycles(off_cycles),
    .fast_pick_o(fast_pick), .fast_last_o(fast_last), .off_last_o(off_last)
  );

  pwm_chopper_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir(dir),
    .sense_trip(sense_trip), .zero_cross(zero_cross), .armed(armed),
    .fast_pick(fast_pick), .fast_last(fast_last), .off_last(off_last),
    .ph_o(ph), .restart_o(restart), .load_o(load), .adv_o(adv),
    .pol_o(pol), .zflag_o(zflag)
  );

  pwm_chopper_gates u_gates (
    .enable(enable), .ph(ph), .pol(pol), .dead(dead),
    .zero_cross(zero_cross), .zflag(zflag), .gv_o(gv)
  );

  assign {gate_ah, gate_al, gate_bh, gate_bl} = gv;

endmodule

// File: rtl/pwm_chopper_check.sv
module pwm_chopper_check
  import pwm_chopper_pkg::*;
#(
  parameter int unsigned PC_W = 3,
  parameter int unsigned WIN  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            sense_trip,
  input logic            zero_cross,
  input logic [3:0]      gv,
  input logic [1:0]      ph,
  input logic [PC_W-1:0] pc
);

  localparam logic [PC_W-1:0] WIN_V = PC_W'(WIN);

  logic in_off;
  assign in_off = (ph == PH_FAST) || (ph == PH_SLOW);

  p_leg_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gv[3] && gv[2]));

  p_leg_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gv[1] && gv[0]));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ph == PH_IDLE));

  p_dead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != $past(ph)) |-> (gv == 4'b0000));

  p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ph == PH_DRIVE && pc != WIN_V) |=> (ph == PH_DRIVE) || (ph == PH_IDLE));

  p_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ph == PH_DRIVE && pc == WIN_V && sense_trip) |=> in_off || (ph == PH_IDLE));

  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_off && zero_cross) |=> (ph == PH_DRIVE) || (ph == PH_IDLE) || (gv == 4'b0000));

endmodule

bind pwm_chopper pwm_chopper_check #(.PC_W(PC_W), .WIN(WIN)) u_check (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sense_trip(sense_trip),
  .zero_cross(zero_cross), .gv(gv), .ph(ph), .pc(pc)
);

// File: tb/pwm_chopper_test.sv
module pwm_chopper_test;

  localparam int CLK_PERIOD = 10;
  localparam int OFF_W   = 8;
  localparam int DEAD    = 1;
  localparam int MHZ     = 4;
  localparam int WIN     = DEAD + MHZ;
  localparam int DEF_OFF = 30 * MHZ;

  logic clk = 1'b0;
  logic rst_n, enable, dir, mixed_req, sense_trip, zero_cross;
  logic [OFF_W-1:0] off_cycles;
  logic g_ah, g_al, g_bh, g_bl;
  wire  [3:0] gates = {g_ah, g_al, g_bh, g_bl};

  int checks = 0;
  int errors = 0;
  int leg_viol = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_chopper #(.OFF_W(OFF_W), .DEAD_CYC(DEAD), .CLK_MHZ(MHZ), .ROSC_OHM(0)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir(dir), .mixed_req(mixed_req),
    .sense_trip(sense_trip), .zero_cross(zero_cross), .off_cycles(off_cycles),
    .gate_ah(g_ah), .gate_al(g_al), .gate_bh(g_bh), .gate_bl(g_bl)
  );

  task automatic chk(input logic [3:0] exp, input string tag);
    checks++;
    if (gates !== exp) begin
      errors++;
      $display("FAIL %s: gates=%b expected %b at %0t", tag, gates, exp, $time);
    end
  endtask

  function automatic logic [3:0] model(input int c, input bit d, input bit m, input int off);
    int eff, f, t, p, j, s;
    eff = (off == 0) ? DEF_OFF : off;
    f = eff * 5 / 16;
    t = WIN + 1 + eff;
    p = c % t;
    if (p <= WIN) return (p >= DEAD) ? (d ? 4'b1001 : 4'b0110) : 4'b0000;
    j = p - WIN - 1;
    if (m && f > 0 && j < f) return (j >= DEAD) ? (d ? 4'b0110 : 4'b1001) : 4'b0000;
    s = (m && f > 0) ? j - f : j;
    return (s >= DEAD) ? 4'b0101 : 4'b0000;
  endfunction

  function automatic string tag_of(input int c, input bit m, input int off);
    int eff, t, p;
    eff = (off == 0) ? DEF_OFF : off;
    t = WIN + 1 + eff;
    p = c % t;
    if (off == 0) return "R9";
    if (c >= t) return "R10";
    if (p < DEAD || p == WIN + 1) return "R3";
    if (p <= WIN) return "R2";
    return m ? "R6" : "R7";
  endfunction

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  task automatic start_run(input bit d, input bit m, input int off, input bit s);
    nxt();
    enable = 1'b1; dir = d; mixed_req = m; off_cycles = OFF_W'(off);
    sense_trip = s; zero_cross = 1'b0;
    @(negedge clk);
    chk(4'b0000, "R1 idle before first edge");
    nxt();
  endtask

  task automatic end_run();
    nxt();
    enable = 1'b0; sense_trip = 1'b0; zero_cross = 1'b0;
    @(negedge clk);
    chk(4'b0000, "R1 enable low");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int offs[13] = '{0, 1, 2, 3, 4, 5, 6, 7, 15, 16, 17, 100, 255};
    logic [3:0] eb[26];
    logic [3:0] ez[24];
    rst_n = 1'b0; enable = 1'b1; dir = 1'b1; mixed_req = 1'b0;
    sense_trip = 1'b0; zero_cross = 1'b0; off_cycles = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(4'b0000, "R1 reset");
    #1 enable = 1'b0;
    nxt();
    rst_n = 1'b1;
    nxt();
    @(negedge clk);
    chk(4'b0000, "R1 disabled after reset");

    // shorted-load sweep: two full periods per configuration
    for (int oi = 0; oi < 13; oi++) begin
      for (int dm = 0; dm < 4; dm++) begin
        int eff, t;
        eff = (offs[oi] == 0) ? DEF_OFF : offs[oi];
        t = WIN + 1 + eff;
        start_run(dm[0], dm[1], offs[oi], 1'b1);
        for (int c = 0; c < 2 * t; c++) begin
          @(negedge clk);
          if ((gates[3] && gates[2]) || (gates[1] && gates[0])) leg_viol++;
          chk(model(c, dm[0], dm[1], offs[oi]), tag_of(c, dm[1], offs[oi]));
        end
        end_run();
      end
    end
    checks++;
    if (leg_viol != 0) begin
      errors++;
      $display("FAIL R11: leg conflicts=%0d expected 0", leg_viol);
    end

    // blanking boundary, polarity latch, sampling at trip
    eb = '{4'b0000, 4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b0000,
           4'b0101, 4'b0101, 4'b0101, 4'b0101, 4'b0101, 4'b0101, 4'b0101,
           4'b0000, 4'b0110, 4'b0110, 4'b0110, 4'b0110, 4'b0110, 4'b0110,
           4'b0000, 4'b0101, 4'b0101, 4'b0000, 4'b0110};
    start_run(1'b1, 1'b0, 8, 1'b0);
    for (int c = 0; c < 26; c++) begin
      sense_trip = (c == 2 || c == 4 || c == 5 || c == 20);
      if (c == 2) dir = 1'b0;
      if (c == 7) begin off_cycles = OFF_W'(3); mixed_req = 1'b1; end
      @(negedge clk);
      if (c <= 5)       chk(eb[c], "R4 blanking window");
      else if (c <= 13) chk(eb[c], "R12 off phase keeps sampled setting");
      else if (c <= 15) chk(eb[c], "R5 drive after off with new dir R2");
      else if (c >= 21) chk(eb[c], "R7 zero fast share gives slow only");
      else              chk(eb[c], "R3 drive hold");
      nxt();
    end
    end_run();

    // zero-current release during mixed decay
    ez = '{4'b0000, 4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b0000,
           4'b0110, 4'b0110, 4'b0110, 4'b0110, 4'b0000, 4'b0101, 4'b0101,
           4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
           4'b0000, 4'b0000, 4'b1001};
    start_run(1'b1, 1'b1, 16, 1'b1);
    for (int c = 0; c < 24; c++) begin
      zero_cross = (c == 14);
      if (c >= 22) sense_trip = 1'b0;
      @(negedge clk);
      if (c >= 14 && c <= 21) chk(ez[c], "R8 released after zero current");
      else if (c == 23)       chk(ez[c], "R8 next drive unaffected");
      else                    chk(ez[c], "R6 mixed before zero current");
      nxt();
    end
    end_run();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule